// File: doc/BRIEF.md
# Reflected CRC-8 Accumulator

This block keeps the running 8-bit check value that travels with the bytes of a single-wire serial protocol. The generator polynomial is x^8 + x^5 + x^4 + 1. Each byte enters least significant bit first. For that reason the register shifts right and uses the bit-reversed form of the polynomial, 0x8C. A whole byte is folded into the register in one clock. The eight single-bit steps are chained combinationally to do this.

The surrounding protocol logic decides which bytes are covered. It presents each covered byte with a one-cycle strobe. It can clear the register at any time. When the check value must go out on the wire, the protocol logic pulses a start input. The block then presents the value one bit per cycle, least significant bit first. After the last bit it returns to zero by itself, ready for the next covered stretch. Bus timing is handled elsewhere.

Top module: `crc8r_accum`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `crc_o` is 0x00 and `sout_valid_o` is 0.
- R2: When a strobe is accepted on `byte_valid_i`, `crc_o` shows the updated value from the next cycle on. The update processes the 8 bits of `byte_i` from bit 0 to bit 7. For each bit, if CRC bit 0 XOR the data bit is 1, the register shifts right and is then XORed with 0x8C. Otherwise it only shifts right. From zero, byte 0x01 gives 0x5E, and the ASCII string "123456789" gives 0xA1.
- R3: In an idle cycle with no strobe, no clear and no start, `crc_o` keeps its value.
- R4: `clr_i` sets `crc_o` to 0x00 in the next cycle. If `byte_valid_i` is high in the same cycle, that byte is folded in starting from zero.
- R5: A `sout_start_i` pulse in an idle cycle without `clr_i` starts a shift-out. For the next 8 cycles `sout_valid_o` is 1 and `sout_bit_o` carries bits 0 through 7 of the value `crc_o` held at the start, in that order. `crc_o` keeps that value during the shift-out.
- R6: In the cycle after the eighth bit, `sout_valid_o` is 0 and `crc_o` is 0x00, without any clear.
- R7: During a shift-out, strobes on `byte_valid_i` and pulses on `sout_start_i` have no effect.
- R8: `clr_i` during a shift-out ends it at once: in the next cycle `sout_valid_o` is 0 and `crc_o` is 0x00.
- R9: If `sout_start_i` and `byte_valid_i` arrive together in an idle cycle, the byte is dropped. The value shifted out is the one from before that cycle.
- R10: After a message of bytes followed by its own CRC byte has been folded in from zero, `crc_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear the register; has priority over everything else |
| byte_valid_i | input | 1 | Strobe: fold `byte_i` into the register |
| byte_i | input | 8 | Data byte, processed bit 0 first |
| sout_start_i | input | 1 | Begin serial shift-out of the current value |
| crc_o | output | 8 | Current check value |
| sout_valid_o | output | 1 | A shift-out bit is present on `sout_bit_o` |
| sout_bit_o | output | 1 | Serial check value bit, LSB first |

## Verification
The bench uses the default widths: an 8-bit register, 8-bit bytes and the reversed constant 0x8C. At these widths the published check results (0x5E for byte 0x01, 0xA1 for "123456789") can be compared directly. A shift-out lasts a short 8 cycles, so the bench can fire clears, strobes and starts on the first bit, on a middle bit and on the last bit of a shift-out. A random phase mixes all four controls and covers their priority order against the reference model cycle by cycle.

// File: rtl/crc8r_pkg.sv
package crc8r_pkg;
    localparam int unsigned CRC_W_DEF    = 8;
    localparam int unsigned DATA_W_DEF   = 8;
    localparam logic [7:0]  POLY_REV_DEF = 8'h8C;

    typedef enum logic [0:0] {
        MODE_IDLE  = 1'b0,
        MODE_SHIFT = 1'b1
    } crc8r_mode_e;
endpackage

// File: rtl/crc8r_bit_step.sv
module crc8r_bit_step #(
    parameter int unsigned   CRC_W    = 8,
    parameter logic [CRC_W-1:0] POLY_REV = 8'h8C
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             din,
    output logic [CRC_W-1:0] crc_out
);
    logic feedback;

    always_comb begin
        feedback = crc_in[0] ^ din;
        crc_out  = feedback ? ((crc_in >> 1) ^ POLY_REV) : (crc_in >> 1);
    end
endmodule

// File: rtl/crc8r_byte_step.sv
module crc8r_byte_step #(
    parameter int unsigned      CRC_W    = 8,
    parameter int unsigned      DATA_W   = 8,
    parameter logic [CRC_W-1:0] POLY_REV = 8'h8C
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] chain [DATA_W+1];

    assign chain[0] = crc_in;

    // Bit 0 of the data enters first: stage k consumes data_in[k].
    for (genvar k = 0; k < DATA_W; k++) begin : g_stage
        crc8r_bit_step #(
            .CRC_W   (CRC_W),
            .POLY_REV(POLY_REV)
        ) u_bit (
            .crc_in (chain[k]),
            .din    (data_in[k]),
            .crc_out(chain[k+1])
        );
    end

    assign crc_out = chain[DATA_W];
endmodule

// File: rtl/crc8r_accum.sv
module crc8r_accum
    import crc8r_pkg::*;
#(
    parameter int unsigned      CRC_W    = CRC_W_DEF,
    parameter int unsigned      DATA_W   = DATA_W_DEF,
    parameter logic [CRC_W-1:0] POLY_REV = POLY_REV_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              sout_start_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              sout_valid_o,
    output logic              sout_bit_o
);
    localparam int unsigned     CNT_W    = (CRC_W > 1) ? $clog2(CRC_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CRC_W - 1);

    typedef struct packed {
        crc8r_mode_e      mode;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] sh;
    } st_t;

    st_t              st_d, st_q;
    logic [CRC_W-1:0] base_crc;
    logic [CRC_W-1:0] stepped_crc;

    // A clear restarts the fold from zero in the same cycle.
    assign base_crc = clr_i ? '0 : st_q.crc;

    crc8r_byte_step #(
        .CRC_W   (CRC_W),
        .DATA_W  (DATA_W),
        .POLY_REV(POLY_REV)
    ) u_step (
        .crc_in (base_crc),
        .data_in(byte_i),
        .crc_out(stepped_crc)
    );

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.mode = MODE_IDLE;
            st_d.cnt  = '0;
            st_d.crc  = byte_valid_i ? stepped_crc : '0;
        end else if (st_q.mode == MODE_SHIFT) begin
            st_d.sh  = st_q.sh >> 1;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_BIT) begin
                st_d.mode = MODE_IDLE;
                st_d.cnt  = '0;
                st_d.crc  = '0;
            end
        end else if (sout_start_i) begin
            st_d.mode = MODE_SHIFT;
            st_d.cnt  = '0;
            st_d.sh   = st_q.crc;
        end else if (byte_valid_i) begin
            st_d.crc = stepped_crc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, cnt: '0, crc: '0, sh: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o        = st_q.crc;
    assign sout_valid_o = (st_q.mode == MODE_SHIFT);
    assign sout_bit_o   = st_q.sh[0];

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sout_valid_o && !clr_i && !sout_start_i && !byte_valid_i) |=> $stable(crc_o));

    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !byte_valid_i) |=> (crc_o == '0 && !sout_valid_o));

    // R5
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sout_valid_o && !clr_i && sout_start_i)
            |=> (sout_valid_o && sout_bit_o == $past(crc_o[0]) && $stable(crc_o)));

    // R6
    auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sout_valid_o) && !$past(clr_i)) |-> (crc_o == '0));

    // R7
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sout_valid_o && !clr_i && st_q.cnt != LAST_BIT)
            |=> (sout_valid_o && $stable(crc_o)));
endmodule

// File: tb/tb_crc8r_accum.sv
`timescale 1ns/100ps
module tb_crc8r_accum;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       sout_start_i = 1'b0;
    logic [7:0] crc_o;
    logic       sout_valid_o;
    logic       sout_bit_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    crc8r_accum dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .byte_valid_i(byte_valid_i),
        .byte_i      (byte_i),
        .sout_start_i(sout_start_i),
        .crc_o       (crc_o),
        .sout_valid_o(sout_valid_o),
        .sout_bit_o  (sout_bit_o)
    );

    // Behavioural reference: the reversed constant is derived from x^8+x^5+x^4+1.
    function automatic int rev_poly();
        int p = 'h31;
        int r = 0;
        for (int i = 0; i < 8; i++) if ((p >> i) & 1) r |= 1 << (7 - i);
        return r;
    endfunction

    function automatic int ref_fold(int crc, int b);
        int c = crc;
        for (int i = 0; i < 8; i++) begin
            if (((c ^ (b >> i)) & 1) != 0) c = (c >> 1) ^ rev_poly();
            else                           c = c >> 1;
        end
        return c & 'hFF;
    endfunction

    int m_crc = 0;
    bit m_bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_crc = 0;
            m_bits.delete();
        end else if (clr_i) begin
            m_bits.delete();
            m_crc = byte_valid_i ? ref_fold(0, byte_i) : 0;
        end else if (m_bits.size() > 0) begin
            void'(m_bits.pop_front());
            if (m_bits.size() == 0) m_crc = 0;
        end else if (sout_start_i) begin
            for (int i = 0; i < 8; i++) m_bits.push_back(((m_crc >> i) & 1) != 0);
        end else if (byte_valid_i) begin
            m_crc = ref_fold(m_crc, byte_i);
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R2 R5 R6 R7 R8 R9).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model crc_o", crc_o, m_crc);
            chk("R5 model sout_valid_o", sout_valid_o, m_bits.size() > 0);
            if (m_bits.size() > 0) chk("R5 model sout_bit_o", sout_bit_o, m_bits[0]);
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic send(int b);
        byte_valid_i = 1'b1; byte_i = 8'(b);
        cyc();
        byte_valid_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v;
        int bits;
        string s = "123456789";
        repeat (3) cyc();
        chk("R1 reset crc_o", crc_o, 0);
        chk("R1 reset sout_valid_o", sout_valid_o, 0);
        rst_n = 1'b1;
        cyc();
        chk("R1 after release crc_o", crc_o, 0);

        send('h01);
        chk("R2 byte 01", crc_o, 'h5E);
        clr_i = 1'b1; cyc(); clr_i = 1'b0;
        chk("R4 clear", crc_o, 0);

        for (int i = 0; i < s.len(); i++) send(s[i]);
        chk("R2 check string", crc_o, 'hA1);
        repeat (3) cyc();
        chk("R3 idle hold", crc_o, 'hA1);

        // Shift-out with strobes and starts thrown in (R5, R7, R6).
        sout_start_i = 1'b1; cyc(); sout_start_i = 1'b0;
        bits = 0;
        for (int i = 0; i < 8; i++) begin
            chk("R5 valid during shift", sout_valid_o, 1);
            bits |= int'(sout_bit_o) << i;
            chk("R7 crc held during shift", crc_o, 'hA1);
            byte_valid_i = 1'b1; byte_i = 8'h5A; sout_start_i = (i == 3);
            cyc();
        end
        byte_valid_i = 1'b0; sout_start_i = 1'b0;
        chk("R5 shifted value LSB first", bits, 'hA1);
        chk("R6 valid drops", sout_valid_o, 0);
        chk("R6 auto clear", crc_o, 0);

        // Residue property.
        send('h12); send('h34); send('hAB);
        v = crc_o;
        send(v);
        chk("R10 residue", crc_o, 0);

        // Clear with strobe in the same cycle.
        send('h77);
        clr_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h01; cyc();
        clr_i = 1'b0; byte_valid_i = 1'b0;
        chk("R4 clear plus byte", crc_o, 'h5E);

        // Abort mid-shift.
        sout_start_i = 1'b1; cyc(); sout_start_i = 1'b0;
        repeat (3) cyc();
        clr_i = 1'b1; cyc(); clr_i = 1'b0;
        chk("R8 abort valid", sout_valid_o, 0);
        chk("R8 abort crc", crc_o, 0);

        // Start and strobe together.
        send('h01);
        sout_start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'hFF; cyc();
        sout_start_i = 1'b0; byte_valid_i = 1'b0;
        bits = 0;
        for (int i = 0; i < 8; i++) begin
            bits |= int'(sout_bit_o) << i;
            cyc();
        end
        chk("R9 strobe dropped at start", bits, 'h5E);
        chk("R9 cleared afterwards", crc_o, 0);

        // Random mix; the per-cycle model checks every cycle (R2 R7 R8 R9).
        for (int n = 0; n < 3000; n++) begin
            clr_i        = ($urandom_range(0, 15) == 0);
            sout_start_i = ($urandom_range(0, 9) == 0);
            byte_valid_i = ($urandom_range(0, 1) == 1);
            byte_i       = 8'($urandom_range(0, 255));
            cyc();
        end
        clr_i = 1'b0; sout_start_i = 1'b0; byte_valid_i = 1'b0;
        repeat (10) cyc();
        finish_run();
    end
endmodule